// File: doc/BRIEF.md
# Serial Transmit Channel with Holding Queue

This block is the sending half of a classic asynchronous serial port. The host writes bytes through a simple write strobe. In queued mode the bytes enter a first-in first-out store that holds up to 128 entries. In direct mode they sit in a one-byte holding slot. A shift engine takes one byte at a time and puts it on the line as a start bit, five to eight data bits with the least significant bit first, an optional odd or even parity bit, and one or two stop bits.

The bit period comes from three stages. A prescaler divides the clock by 1 or 4. A divisor input follows it. The last stage is an oversampling count of 16, or 8 at double rate. Two status outputs tell the host when the holding stage is empty and when the whole transmitter has gone idle. An interrupt output, gated by its own enable, reports that the queue needs refilling. In queued mode it fires when the fill level drops below a host-set threshold and again when the queue runs dry.

Top module: `uart_tx_core`

## Requirements
- R1: While `rst` is high and after it is released, `txOut` is 1, `thrEmpty` is 1, `txEmpty` is 1 and `txIrq` is 0, even if a character was being sent when reset arrived.
- R2: A character is sent as one low start bit, then `wordLen`+5 data bits with bit 0 first (`wordLen` 0..3 selects 5..8 bits, higher data bits are ignored), then one high stop bit, or two when `stopTwo` is 1.
- R3: With `parEn` at 1, a parity bit follows the last data bit. With `parEven` at 1 it equals the XOR of the sent data bits (even parity); with `parEven` at 0 it is the inverse (odd parity).
- R4: Every bit lasts P*D*S clock cycles: S is 16, or 8 when `samp8x` is 1; D is `baudDiv`, with 0 treated as 1; P is the prescale factor of R5.
- R5: The prescale factor is 4 if `preDiv4Strap` was 1 while `rst` was high, otherwise 1. A cycle with `ovrWe` at 1 replaces it with 4 (`ovrDiv4`=1) or 1 (`ovrDiv4`=0).
- R6: With `fifoEn` at 0 the block holds a single byte. `thrEmpty` drops the cycle after a write and returns to 1 in the cycle after the byte moves into the shift engine. A write while the slot is occupied replaces the waiting byte.
- R7: With `fifoEn` at 1 up to 128 bytes queue behind the character being sent, in write order. Writes to a full queue are dropped. `thrEmpty` is 1 exactly when the queue is empty. Queued characters follow each other with no idle time between the last stop bit and the next start bit.
- R8: `txEmpty` is 1 only when both the shift engine and the holding stage are empty, and the line is then high.
- R9: An interrupt becomes pending when the shift engine takes a byte and one of three conditions holds. In direct mode it is any transfer. In queued mode it is a transfer that takes the fill level from at least `trigLevel` to below it, or a transfer that empties the queue. `txIrq` is the pending flag ANDed with `ierTx`.
- R10: A write or an `isrRd` pulse clears the pending interrupt, and this takes priority over a new pending event in the same cycle.
- R11: Changing `fifoEn` discards every byte that is still waiting, but not the character already in the shift engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| preDiv4Strap | input | 1 | Prescale choice captured during reset (1 = divide by 4) |
| ovrWe | input | 1 | Replaces the prescale choice with `ovrDiv4` |
| ovrDiv4 | input | 1 | New prescale choice (1 = divide by 4) |
| samp8x | input | 1 | 1 = 8 sample periods per bit, 0 = 16 |
| baudDiv | input | DIV_W | Sample-rate divisor (0 acts as 1) |
| fifoEn | input | 1 | 1 = queued mode, 0 = single holding byte |
| wordLen | input | 2 | Data bits minus 5 |
| parEn | input | 1 | Parity bit enable |
| parEven | input | 1 | 1 = even parity, 0 = odd |
| stopTwo | input | 1 | 1 = two stop bits |
| trigLevel | input | CNT_W | Refill threshold for the interrupt |
| ierTx | input | 1 | Interrupt enable |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Byte to send |
| isrRd | input | 1 | Interrupt status read, clears the pending interrupt |
| txOut | output | 1 | Serial line, idles high |
| thrEmpty | output | 1 | Holding stage or queue empty |
| txEmpty | output | 1 | Transmitter fully idle |
| txIrq | output | 1 | Transmit-empty interrupt |

## Verification
The bound checker watches relations that must hold on every cycle. The line stays high whenever the transmitter is idle, and idle implies an empty holding stage. The interrupt stays silent while disabled and clears after a write or a status read. The fill level never exceeds the queue depth, or one byte in direct mode. A start bit only ever comes from a busy transmitter. Other behaviours can only be shown by the bench's scenarios, which decode whole frames from the line: bit order, parity polarity, masking of short words, exact bit lengths under each prescale and sampling choice, replacement of a waiting byte, dropping on overflow, the gapless queue, the threshold crossings and the flush on a mode change.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } txPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;   // pop head byte into the shift engine
    logic     shift;  // advance to the next data bit
    logic     flush;  // discard waiting bytes
    txPhase_e phase;  // which part of the frame is on the line
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preDiv4Strap,
  input  logic             ovrWe,
  input  logic             ovrDiv4,
  input  logic             samp8x,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             fifoEn,
  input  logic [1:0]       wordLen,
  input  logic             parEn,
  input  logic             stopTwo,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             wrEn,
  input  logic             isrRd,
  output txStrobe_t        ctl,
  output logic             irqPend
);

  logic             div4;
  logic [1:0]       preCnt;
  logic [DIV_W-1:0] divCnt, divLast;
  logic [3:0]       sampCnt, osLast;
  txPhase_e         phase, phaseNxt;
  logic [2:0]       bitIdx, lastIdx;
  logic             stopIdx, twoStops, useParity, fifoEnQ;
  logic             preTick, sampTick, bitDone, flush, avail, frameEnd, load, setEv, crossDown;

  // timing chain: prescaler -> divisor -> oversampling count
  always_comb begin
    divLast  = (baudDiv == '0) ? '0 : baudDiv - 1'b1;
    osLast   = samp8x ? 4'd7 : 4'd15;
    preTick  = !div4 || (preCnt == 2'd3);
    sampTick = preTick && (divCnt == divLast);
    bitDone  = (phase != PH_IDLE) && sampTick && (sampCnt == osLast);
  end

  always_comb begin
    flush    = (fifoEn != fifoEnQ);
    avail    = (fifoCount != '0) && !flush;
    frameEnd = (phase == PH_STOP) && bitDone && (!twoStops || stopIdx);
    load     = avail && ((phase == PH_IDLE) || frameEnd);
  end

  always_comb begin
    phaseNxt = phase;
    unique case (phase)
      PH_IDLE:  phaseNxt = PH_IDLE;
      PH_START: if (bitDone) phaseNxt = PH_DATA;
      PH_DATA:  if (bitDone && (bitIdx == lastIdx)) phaseNxt = useParity ? PH_PAR : PH_STOP;
      PH_PAR:   if (bitDone) phaseNxt = PH_STOP;
      PH_STOP:  if (frameEnd) phaseNxt = PH_IDLE;
      default:  phaseNxt = PH_IDLE;
    endcase
    if (load) phaseNxt = PH_START;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div4      <= preDiv4Strap;
      fifoEnQ   <= fifoEn;
      phase     <= PH_IDLE;
      preCnt    <= '0;
      divCnt    <= '0;
      sampCnt   <= '0;
      bitIdx    <= '0;
      stopIdx   <= 1'b0;
      lastIdx   <= 3'd7;
      useParity <= 1'b0;
      twoStops  <= 1'b0;
    end else begin
      if (ovrWe) div4 <= ovrDiv4;
      fifoEnQ <= fifoEn;
      phase   <= phaseNxt;
      if (load) begin
        preCnt    <= '0;
        divCnt    <= '0;
        sampCnt   <= '0;
        bitIdx    <= '0;
        stopIdx   <= 1'b0;
        lastIdx   <= 3'd4 + {1'b0, wordLen};
        useParity <= parEn;
        twoStops  <= stopTwo;
      end else if (phase != PH_IDLE) begin
        if (div4) preCnt <= preCnt + 1'b1;
        if (preTick) divCnt <= (divCnt == divLast) ? '0 : divCnt + 1'b1;
        if (sampTick) sampCnt <= (sampCnt == osLast) ? '0 : sampCnt + 1'b1;
        if ((phase == PH_DATA) && bitDone) bitIdx <= bitIdx + 1'b1;
        if ((phase == PH_STOP) && bitDone) stopIdx <= 1'b1;
      end
    end
  end

  // interrupt source
  always_comb begin
    crossDown = (fifoCount >= trigLevel) && ((fifoCount - 1'b1) < trigLevel);
    setEv     = load && (!fifoEn || (fifoCount == CNT_W'(1)) || crossDown);
  end

  always_ff @(posedge clk) begin
    if (rst)                 irqPend <= 1'b0;
    else if (wrEn || isrRd)  irqPend <= 1'b0;
    else if (setEv)          irqPend <= 1'b1;
  end

  always_comb begin
    ctl.load  = load;
    ctl.shift = (phase == PH_DATA) && bitDone;
    ctl.flush = flush;
    ctl.phase = phase;
  end

endmodule

// File: rtl/uart_tx_dpath.sv
module uart_tx_dpath
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifoEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        wordLen,
  input  logic              parEven,
  input  txStrobe_t         ctl,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              txOut
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, memAddr;
  logic [DATA_W-1:0] headData, mask, shiftReg;
  logic              full, wrAcc, memWe, parBit;

  always_comb begin
    full    = (fifoCount == CNT_W'(DEPTH));
    wrAcc   = wrEn && !ctl.flush && (!fifoEn || !full || ctl.load);
    memWe   = wrAcc;
    memAddr = fifoEn ? wrPtr : '0;
    headData = mem[rdPtr];
    mask    = 8'hFF >> (2'd3 - wordLen);
  end

  always_ff @(posedge clk) begin
    if (memWe) mem[memAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else if (wrAcc && !fifoEn) begin
      // single holding byte: a new write always ends up as the only entry
      wrPtr     <= PTR_W'(1);
      rdPtr     <= '0;
      fifoCount <= CNT_W'(1);
    end else begin
      if (wrAcc)    wrPtr <= wrPtr + 1'b1;
      if (ctl.load) rdPtr <= rdPtr + 1'b1;
      unique case ({wrAcc, ctl.load})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (ctl.load) begin
      shiftReg <= headData & mask;
      parBit   <= (^(headData & mask)) ^ !parEven;
    end else if (ctl.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    unique case (ctl.phase)
      PH_START: txOut = 1'b0;
      PH_DATA:  txOut = shiftReg[0];
      PH_PAR:   txOut = parBit;
      default:  txOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DIV_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preDiv4Strap,
  input  logic             ovrWe,
  input  logic             ovrDiv4,
  input  logic             samp8x,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             fifoEn,
  input  logic [1:0]       wordLen,
  input  logic             parEn,
  input  logic             parEven,
  input  logic             stopTwo,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             ierTx,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             isrRd,
  output logic             txOut,
  output logic             thrEmpty,
  output logic             txEmpty,
  output logic             txIrq
);

  txStrobe_t        ctl;
  logic [CNT_W-1:0] fifoCount;
  logic             irqPend;

  uart_tx_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .preDiv4Strap(preDiv4Strap), .ovrWe(ovrWe), .ovrDiv4(ovrDiv4),
    .samp8x(samp8x), .baudDiv(baudDiv), .fifoEn(fifoEn), .wordLen(wordLen), .parEn(parEn),
    .stopTwo(stopTwo), .fifoCount(fifoCount), .trigLevel(trigLevel), .wrEn(wrEn),
    .isrRd(isrRd), .ctl(ctl), .irqPend(irqPend)
  );

  uart_tx_dpath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .fifoEn(fifoEn), .wrEn(wrEn), .wrData(wrData), .wordLen(wordLen),
    .parEven(parEven), .ctl(ctl), .fifoCount(fifoCount), .txOut(txOut)
  );

  assign thrEmpty = (fifoCount == '0);
  assign txEmpty  = thrEmpty && (ctl.phase == PH_IDLE);
  assign txIrq    = irqPend && ierTx;

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             fifoEn,
  input logic             ierTx,
  input logic             wrEn,
  input logic             isrRd,
  input logic             txOut,
  input logic             thrEmpty,
  input logic             txEmpty,
  input logic             txIrq,
  input logic [CNT_W-1:0] fifoCount
);

  a_r8_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    txEmpty |-> txOut);

  a_r8_idle_needs_empty_holding: assert property (@(posedge clk) disable iff (rst)
    txEmpty |-> thrEmpty);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !ierTx |-> !txIrq);

  a_r10_clear_on_access: assert property (@(posedge clk) disable iff (rst)
    (wrEn || isrRd) |=> !txIrq);

  a_r2_start_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(txOut) |-> !txEmpty);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fifoCount <= CNT_W'(DEPTH));

  a_r6_single_slot: assert property (@(posedge clk) disable iff (rst)
    (!fifoEn && !$past(fifoEn)) |-> (fifoCount <= CNT_W'(1)));

endmodule

bind uart_tx_core uart_tx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fifoEn(fifoEn), .ierTx(ierTx), .wrEn(wrEn), .isrRd(isrRd),
  .txOut(txOut), .thrEmpty(thrEmpty), .txEmpty(txEmpty), .txIrq(txIrq), .fifoCount(fifoCount)
);

// File: tb/sim_uart_tx_core.sv
module sim_uart_tx_core;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic preDiv4Strap = 1'b0, ovrWe = 1'b0, ovrDiv4 = 1'b0, samp8x = 1'b0;
  logic [15:0] baudDiv = 16'd1;
  logic fifoEn = 1'b0, parEn = 1'b0, parEven = 1'b0, stopTwo = 1'b0;
  logic [1:0] wordLen = 2'd3;
  logic [7:0] trigLevel = 8'd1;
  logic ierTx = 1'b0, wrEn = 1'b0, isrRd = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic txOut, thrEmpty, txEmpty, txIrq;

  int nChecks = 0, nFail = 0, cyc = 0, bitN = 16;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_core u0 (
    .clk(clk), .rst(rst), .preDiv4Strap(preDiv4Strap), .ovrWe(ovrWe), .ovrDiv4(ovrDiv4),
    .samp8x(samp8x), .baudDiv(baudDiv), .fifoEn(fifoEn), .wordLen(wordLen), .parEn(parEn),
    .parEven(parEven), .stopTwo(stopTwo), .trigLevel(trigLevel), .ierTx(ierTx), .wrEn(wrEn),
    .wrData(wrData), .isrRd(isrRd), .txOut(txOut), .thrEmpty(thrEmpty), .txEmpty(txEmpty),
    .txIrq(txIrq)
  );

  // {expData, data, wordLen, parEn, parEven, stopTwo, expPar, nBits}
  localparam logic [25:0] VEC [6] = '{
    {8'h55, 8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
    {8'hA3, 8'hA3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},
    {8'hA3, 8'hA3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8},
    {8'h1F, 8'hFF, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd5},
    {8'h2C, 8'h2C, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
    {8'h7E, 8'hFE, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic doReset(input logic strap);
    rst = 1'b1; preDiv4Strap = strap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wrByte(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitStart(output int sc, output bit ok);
    ok = 0; sc = 0;
    for (int i = 0; i < 20000; i++) begin
      if (txOut == 1'b0) begin ok = 1; sc = cyc; return; end
      @(negedge clk);
    end
  endtask

  task automatic waitNextStart(output bit ok);
    int sc;
    for (int i = 0; i < 20000 && txOut == 1'b0; i++) @(negedge clk);
    waitStart(sc, ok);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 40000 && !txEmpty; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic recvFrame(input int nb, input bit pe, input int ns,
                           output logic [7:0] d, output logic p, output bit stOk,
                           output int sc, output bit ok);
    d = 8'h00; p = 1'b0; stOk = 1;
    waitStart(sc, ok);
    repeat (bitN / 2) @(negedge clk);
    if (txOut !== 1'b0) ok = 0;
    for (int i = 0; i < nb; i++) begin
      repeat (bitN) @(negedge clk);
      d[i] = txOut;
    end
    if (pe) begin
      repeat (bitN) @(negedge clk);
      p = txOut;
    end
    for (int s = 0; s < ns; s++) begin
      repeat (bitN) @(negedge clk);
      if (txOut !== 1'b1) stOk = 0;
    end
  endtask

  task automatic measureLow(output int n);
    int sc; bit ok;
    n = 0;
    waitStart(sc, ok);
    while (txOut == 1'b0 && n < 2000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d; logic p; bit stOk, ok; int sc, n, prevSc, errs;

    // R1: reset state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(txOut && thrEmpty && txEmpty && !txIrq, "R1 outputs during reset",
          {txOut, thrEmpty, txEmpty, txIrq}, 4'b1110);
    doReset(1'b0);
    check(txOut && thrEmpty && txEmpty && !txIrq, "R1 outputs after reset",
          {txOut, thrEmpty, txEmpty, txIrq}, 4'b1110);

    // R2 R3: table of frame formats, 16 clocks per bit
    foreach (VEC[k]) begin
      wordLen = VEC[k][9:8]; parEn = VEC[k][7]; parEven = VEC[k][6]; stopTwo = VEC[k][5];
      wrByte(VEC[k][17:10]);
      recvFrame(int'(VEC[k][3:0]), VEC[k][7], VEC[k][5] ? 2 : 1, d, p, stOk, sc, ok);
      check(ok, "R2 start bit low", ok, 1);
      check(d == VEC[k][25:18], "R2 data bits lsb first", d, VEC[k][25:18]);
      if (VEC[k][7]) check(p == VEC[k][4], "R3 parity bit", p, VEC[k][4]);
      check(stOk, "R2 stop bits high", stOk, 1);
      waitIdle();
      check(txEmpty && txOut, "R8 idle after frame", {txEmpty, txOut}, 2'b11);
    end
    wordLen = 2'd3; parEn = 1'b0; stopTwo = 1'b0;

    // R4 R5: bit length under prescale and oversampling choices
    doReset(1'b1);
    wrByte(8'h01); measureLow(n); waitIdle();
    check(n == 64, "R5 strap divide by 4", n, 64);
    ovrWe = 1'b1; ovrDiv4 = 1'b0; @(negedge clk); ovrWe = 1'b0;
    wrByte(8'h01); measureLow(n); waitIdle();
    check(n == 16, "R5 override to divide by 1", n, 16);
    samp8x = 1'b1;
    wrByte(8'h01); measureLow(n); waitIdle();
    check(n == 8, "R4 8x sampling", n, 8);
    baudDiv = 16'd3;
    wrByte(8'h01); measureLow(n); waitIdle();
    check(n == 24, "R4 divisor 3", n, 24);
    baudDiv = 16'd0;
    wrByte(8'h01); measureLow(n); waitIdle();
    check(n == 8, "R4 divisor 0 acts as 1", n, 8);
    ovrWe = 1'b1; ovrDiv4 = 1'b1; baudDiv = 16'd2; @(negedge clk); ovrWe = 1'b0;
    wrByte(8'h01); measureLow(n); waitIdle();
    check(n == 64, "R4 R5 4*2*8", n, 64);

    // R6: direct mode status timing and replacement
    doReset(1'b0);
    samp8x = 1'b0; baudDiv = 16'd1; bitN = 16;
    wrEn = 1'b1; wrData = 8'h11; @(negedge clk); wrEn = 1'b0;
    check(!thrEmpty && !txEmpty, "R6 holding full after write", {thrEmpty, txEmpty}, 0);
    @(negedge clk);
    check(thrEmpty && !txEmpty, "R6 holding empty after transfer", {thrEmpty, txEmpty}, 2);
    wrByte(8'h22);
    check(!thrEmpty, "R6 waiting byte", thrEmpty, 0);
    wrByte(8'h33);
    recvFrame(8, 0, 1, d, p, stOk, sc, ok);
    check(ok && d == 8'h11, "R6 first frame", d, 8'h11);
    recvFrame(8, 0, 1, d, p, stOk, sc, ok);
    check(ok && d == 8'h33, "R6 replaced byte sent", d, 8'h33);
    waitIdle();
    check(txEmpty, "R6 nothing else sent", txEmpty, 1);

    // R9 R10: direct mode interrupt, gate and clear
    ierTx = 1'b0;
    wrByte(8'hF0);
    repeat (3) @(negedge clk);
    check(!txIrq, "R9 disabled interrupt silent", txIrq, 0);
    ierTx = 1'b1; @(negedge clk);
    check(txIrq, "R9 pending shown when enabled", txIrq, 1);
    isrRd = 1'b1; @(negedge clk); isrRd = 1'b0;
    check(!txIrq, "R10 status read clears", txIrq, 0);
    waitIdle();

    // R7: queued mode, overflow drop and gapless frames
    samp8x = 1'b1; bitN = 8; ierTx = 1'b0;
    fifoEn = 1'b1; repeat (2) @(negedge clk);
    errs = 0; prevSc = 0; n = 0;
    fork
      begin
        for (int i = 0; i < 130; i++) begin
          wrEn = 1'b1; wrData = 8'(i); @(negedge clk);
        end
        wrEn = 1'b0;
      end
      begin
        for (int i = 0; i < 129; i++) begin
          recvFrame(8, 0, 1, d, p, stOk, sc, ok);
          if (!ok || d != 8'(i) || !stOk) errs++;
          if (i > 0 && sc - prevSc != 80) n++;
          prevSc = sc;
        end
      end
    join
    check(errs == 0, "R7 queue order and content", errs, 0);
    check(n == 0, "R7 no gap between queued frames", n, 0);
    repeat (3 * 80) @(negedge clk);
    check(txEmpty && txOut && thrEmpty, "R7 write to full queue dropped",
          {txEmpty, txOut, thrEmpty}, 3'b111);

    // R9 R10: threshold crossing and empty events in queued mode
    trigLevel = 8'd3; ierTx = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wrEn = 1'b1; wrData = 8'hFF; @(negedge clk);
    end
    wrEn = 1'b0;
    check(!txIrq && !thrEmpty, "R9 no interrupt while filled", txIrq, 0);
    waitNextStart(ok);
    check(ok && !txIrq, "R9 level 4 to 3 not below", txIrq, 0);
    waitNextStart(ok);
    check(ok && txIrq, "R9 level 3 to 2 crosses threshold", txIrq, 1);
    isrRd = 1'b1; @(negedge clk); isrRd = 1'b0;
    check(!txIrq, "R10 read clears", txIrq, 0);
    waitNextStart(ok);
    check(ok && !txIrq, "R9 level 2 to 1 no new event", txIrq, 0);
    waitNextStart(ok);
    check(ok && txIrq && thrEmpty, "R9 queue emptied", {txIrq, thrEmpty}, 3);
    wrByte(8'hFF);
    check(!txIrq, "R10 write clears", txIrq, 0);
    waitIdle();
    ierTx = 1'b0;

    // R11: mode change discards waiting bytes
    wrByte(8'hC1); wrByte(8'hC2); wrByte(8'hC3);
    fifoEn = 1'b0; @(negedge clk);
    check(thrEmpty && !txEmpty, "R11 flush keeps shifting char", {thrEmpty, txEmpty}, 2);
    recvFrame(8, 0, 1, d, p, stOk, sc, ok);
    check(ok && d == 8'hC1, "R11 frame in progress completes", d, 8'hC1);
    n = 0;
    for (int i = 0; i < 3 * 80; i++) begin
      if (!txOut) n++;
      @(negedge clk);
    end
    check(n == 0 && txEmpty, "R11 discarded bytes not sent", n, 0);

    // R1: reset in the middle of a frame
    wrByte(8'h00);
    repeat (20) @(negedge clk);
    rst = 1'b1; @(negedge clk);
    check(txOut && thrEmpty && txEmpty && !txIrq, "R1 reset mid frame",
          {txOut, thrEmpty, txEmpty, txIrq}, 4'b1110);
    rst = 1'b0;
    repeat (2 * 80) @(negedge clk);
    check(txEmpty && txOut, "R1 line stays idle after reset", {txEmpty, txOut}, 3);

    summary();
  end

endmodule